// File: doc/BRIEF.md
# IR Pulse Duration Capture

This block watches one active-low line shared by a demodulated infrared receiver and a pushbutton, and turns what it sees into either a packet of timed durations or a button event. Time is measured in ticks of an external enable (1/16384 s in the intended system). Starting from a falling edge, the block counts each low (active) span and each high (idle) span, and writes every count as a 16-bit value, low byte first, to a byte-wide buffer write port. An active count and the idle count after it form one four-byte pair.

A packet ends when an idle span grows long enough that the upper byte of its count reaches a timeout value, or when the buffer holds its maximum number of pairs. A low span that hits the same timeout is not IR data but a button press. The block then samples the line at fixed intervals to tell a short press from a long press. After a long press it waits for the line to go high before it accepts another start. The outcome is shown as an event code that stays up until the consumer acknowledges it.

The raw line passes through a two-stage synchronizer before any counting. Ticks must be at least two clock cycles apart, because each stored count takes two write cycles.

Top module: `ir_pulse_capture`

## Requirements
- R1: After reset, event_o is 0 (idle), pair_cnt_o is 0 and wr_en_o is low.
- R2: A capture starts only on a falling edge of the synchronized line while arm_i is high and event_o is 0. The start sets event_o to 1 (receiving) and pair_cnt_o to 0. A falling edge with arm_i low, or while a result code is pending, has no effect.
- R3: Durations are counted in ticks. Pair k stores its active count at byte addresses 4k (low byte) and 4k+1 (high byte), and its idle count at 4k+2 and 4k+3. The high byte is written the cycle after the low byte.
- R4: When the upper byte of an idle count reaches TIMEOUT_HI, that count (TIMEOUT_HI*256) is stored as the idle value of the pair, pair_cnt_o is incremented, and event_o becomes 2 (packet done).
- R5: Once MAX_PAIRS pairs have been stored, event_o becomes 2 and no further bytes are written. pair_cnt_o never exceeds MAX_PAIRS.
- R6: When the upper byte of an active count reaches TIMEOUT_HI, nothing is written for that span. The line is then sampled once every CHECK_TICKS ticks. If it is high at a sample before PRESS_CHECKS samples have passed, event_o becomes 3 (short press).
- R7: If the line is low at PRESS_CHECKS consecutive samples, event_o becomes 4 (long press). No capture restarts until the line has gone high and falls again.
- R8: Codes 2, 3 and 4 stay on event_o until a one-cycle ack_i clears them to 0. ack_i has no effect while event_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle time-grain enable |
| line_i | input | 1 | Raw shared receiver/button line, active low |
| arm_i | input | 1 | Permits a new capture to start |
| ack_i | input | 1 | Clears a pending result code |
| wr_en_o | output | 1 | Buffer byte write strobe |
| wr_addr_o | output | $clog2(MAX_PAIRS)+2 | Buffer byte address |
| wr_data_o | output | 8 | Buffer byte data |
| pair_cnt_o | output | $clog2(MAX_PAIRS+1) | Number of pairs stored |
| event_o | output | 3 | 0 idle, 1 receiving, 2 packet done, 3 short press, 4 long press |

## Verification
The bench builds the block with TIMEOUT_HI=1, MAX_PAIRS=4, CHECK_TICKS=8 and PRESS_CHECKS=3, and drives a tick every four clocks. With these values, both timeouts come within a few hundred ticks. The pair limit is reached with a four-pair packet, which fills the whole 16-byte address space. The short and long press branches, and the wait for the line to go high after a long press, are each reached within a few dozen ticks of the timeout.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;
  typedef enum logic [2:0] {
    EV_IDLE  = 3'd0,
    EV_RECV  = 3'd1,
    EV_DONE  = 3'd2,
    EV_SHORT = 3'd3,
    EV_LONG  = 3'd4
  } cap_event_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_GAP,
    ST_PRESS,
    ST_HOLD
  } cap_state_e;
endpackage

// File: rtl/ir_cap_sync.sv
module ir_cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;  // line idles high
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ir_cap_byte_wr.sv
module ir_cap_byte_wr #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          store_i,
  input  logic [AW-1:0] base_i,
  input  logic [15:0]   val_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o
);
  logic          pend_q;
  logic [7:0]    hi_q;
  logic [AW-1:0] hi_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      hi_q      <= '0;
      hi_addr_q <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else if (store_i) begin
      wr_en_o   <= 1'b1;
      wr_addr_o <= base_i;
      wr_data_o <= val_i[7:0];
      pend_q    <= 1'b1;
      hi_q      <= val_i[15:8];
      hi_addr_q <= {base_i[AW-1:1], 1'b1};
    end else if (pend_q) begin
      wr_en_o   <= 1'b1;
      wr_addr_o <= hi_addr_q;
      wr_data_o <= hi_q;
      pend_q    <= 1'b0;
    end else begin
      wr_en_o   <= 1'b0;
    end
  end

  // ticks must be spaced so a store never lands on a pending high byte
  p_no_store_clash_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_i |-> !pend_q);
  p_hi_follows_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr_o[0]) |-> $past(wr_en_o && !wr_addr_o[0]));
endmodule

// File: rtl/ir_cap_press_timer.sv
module ir_cap_press_timer #(
  parameter int CHECK_TICKS  = 4096,
  parameter int PRESS_CHECKS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic sample_o,
  output logic last_o
);
  localparam int IW = $clog2(CHECK_TICKS + 1);
  localparam int CW = $clog2(PRESS_CHECKS + 1);

  logic [IW-1:0] iv_q;
  logic [CW-1:0] chk_q;

  assign sample_o = tick_i && (iv_q == IW'(CHECK_TICKS - 1));
  assign last_o   = (chk_q == CW'(PRESS_CHECKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iv_q  <= '0;
      chk_q <= '0;
    end else if (clr_i) begin
      iv_q  <= '0;
      chk_q <= '0;
    end else if (sample_o) begin
      iv_q  <= '0;
      chk_q <= chk_q + 1'b1;
    end else if (tick_i) begin
      iv_q  <= iv_q + 1'b1;
    end
  end

  p_chk_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_q <= CW'(PRESS_CHECKS));
endmodule

// File: rtl/ir_pulse_capture.sv
module ir_pulse_capture
  import ir_cap_pkg::*;
#(
  parameter int TIMEOUT_HI   = 2,
  parameter int MAX_PAIRS    = 64,
  parameter int CHECK_TICKS  = 4096,
  parameter int PRESS_CHECKS = 10,
  localparam int AW = $clog2(MAX_PAIRS) + 2,
  localparam int PW = $clog2(MAX_PAIRS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          line_i,
  input  logic          arm_i,
  input  logic          ack_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic [PW-1:0] pair_cnt_o,
  output logic [2:0]    event_o
);
  cap_state_e  state_q, state_d;
  cap_event_e  event_q, ev_val;
  logic [15:0] cnt_q, cnt_d, cnt_inc, store_val;
  logic [PW-1:0] pair_q, pair_d, pair_inc;
  logic lvl, lvl_q, fall, to_hit;
  logic store, store_gap, ev_set, tmr_clr, sample, last;

  ir_cap_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_i), .q_o(lvl)
  );

  ir_cap_press_timer #(.CHECK_TICKS(CHECK_TICKS), .PRESS_CHECKS(PRESS_CHECKS)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(tmr_clr),
    .tick_i(tick_i && state_q == ST_PRESS), .sample_o(sample), .last_o(last)
  );

  ir_cap_byte_wr #(.AW(AW)) u_wr (
    .clk_i(clk_i), .rst_ni(rst_ni), .store_i(store),
    .base_i({pair_q[AW-3:0], store_gap, 1'b0}), .val_i(store_val),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  assign fall     = lvl_q && !lvl;
  assign cnt_inc  = cnt_q + 16'd1;
  assign to_hit   = (cnt_inc[15:8] == 8'(TIMEOUT_HI));
  assign pair_inc = pair_q + 1'b1;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    pair_d    = pair_q;
    store     = 1'b0;
    store_gap = 1'b0;
    store_val = cnt_q;
    ev_set    = 1'b0;
    ev_val    = EV_IDLE;
    tmr_clr   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        tmr_clr = 1'b1;
        if (arm_i && fall && event_q == EV_IDLE) begin
          state_d = ST_ACT;
          cnt_d   = '0;
          pair_d  = '0;
          ev_set  = 1'b1;
          ev_val  = EV_RECV;
        end
      end
      ST_ACT: begin
        tmr_clr = 1'b1;
        if (tick_i) begin
          if (lvl) begin
            store   = 1'b1;
            cnt_d   = 16'd1;  // detecting tick belongs to the new span
            state_d = ST_GAP;
          end else if (to_hit) begin
            state_d = ST_PRESS;
          end else begin
            cnt_d = cnt_inc;
          end
        end
      end
      ST_GAP: begin
        if (tick_i) begin
          if (!lvl || to_hit) begin
            store     = 1'b1;
            store_gap = 1'b1;
            store_val = lvl ? cnt_inc : cnt_q;
            pair_d    = pair_inc;
            cnt_d     = 16'd1;
            if (lvl || pair_inc == PW'(MAX_PAIRS)) begin
              state_d = ST_IDLE;
              ev_set  = 1'b1;
              ev_val  = EV_DONE;
            end else begin
              state_d = ST_ACT;
            end
          end else begin
            cnt_d = cnt_inc;
          end
        end
      end
      ST_PRESS: begin
        if (sample) begin
          if (lvl) begin
            state_d = ST_IDLE;
            ev_set  = 1'b1;
            ev_val  = EV_SHORT;
          end else if (last) begin
            state_d = ST_HOLD;
            ev_set  = 1'b1;
            ev_val  = EV_LONG;
          end
        end
      end
      ST_HOLD: if (lvl) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      event_q <= EV_IDLE;
      cnt_q   <= '0;
      pair_q  <= '0;
      lvl_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pair_q  <= pair_d;
      lvl_q   <= lvl;
      if (ev_set)                           event_q <= ev_val;
      else if (ack_i && event_q >= EV_DONE) event_q <= EV_IDLE;
    end
  end

  assign pair_cnt_o = pair_q;
  assign event_o    = event_q;

  p_start_clears_pairs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_q == EV_RECV && $past(event_q) == EV_IDLE) |-> pair_q == '0);
  p_pair_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_q <= PW'(MAX_PAIRS));
  p_press_no_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PRESS || state_q == ST_HOLD) |-> !store);
  p_hold_until_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && !lvl) |=> state_q == ST_HOLD);
  p_event_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_q >= EV_DONE && !ack_i) |=> event_q == $past(event_q));
endmodule

// File: tb/ir_pulse_capture_tb_top.sv
`timescale 1ns/1ps
module ir_pulse_capture_tb_top;
  localparam int TO = 1, MP = 4, CT = 8, PC = 3;
  localparam int AW = $clog2(MP) + 2;
  localparam int PW = $clog2(MP + 1);

  logic clk_i = 0, rst_ni = 0, tick_i = 0, line_i = 1, arm_i = 0, ack_i = 0;
  logic wr_en_o;
  logic [AW-1:0] wr_addr_o;
  logic [7:0] wr_data_o;
  logic [PW-1:0] pair_cnt_o;
  logic [2:0] event_o;

  int checks = 0, errors = 0, wcount = 0;
  logic [7:0] mem [16];
  logic [1:0] tdiv = 0;

  ir_pulse_capture #(.TIMEOUT_HI(TO), .MAX_PAIRS(MP), .CHECK_TICKS(CT), .PRESS_CHECKS(PC)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .line_i(line_i), .arm_i(arm_i),
    .ack_i(ack_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .pair_cnt_o(pair_cnt_o), .event_o(event_o)
  );

  always #2 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    tdiv   = tdiv + 2'd1;
    tick_i = (tdiv == 2'd0);
    if (rst_ni && wr_en_o) begin
      mem[wr_addr_o] = wr_data_o;
      wcount++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk_i);
      while (!tick_i) @(posedge clk_i);
    end
    @(negedge clk_i);
  endtask

  task automatic clear_mem();
    foreach (mem[i]) mem[i] = 8'hxx;
    wcount = 0;
  endtask

  task automatic pulse_ack();
    @(negedge clk_i); ack_i = 1;
    @(negedge clk_i); ack_i = 0;
  endtask

  task automatic span(input logic lvl, input int n);
    line_i = lvl;
    wait_ticks(n);
  endtask

  task automatic t_reset();
    chk("R1 event", event_o, 0);
    chk("R1 pairs", pair_cnt_o, 0);
    chk("R1 wr_en", wr_en_o, 0);
  endtask

  task automatic t_disarmed();
    clear_mem();
    arm_i = 0;
    wait_ticks(1);
    span(0, 5); span(1, 5);
    chk("R2 disarmed event", event_o, 0);
    chk("R2 disarmed writes", wcount, 0);
  endtask

  task automatic t_timeout_packet();
    clear_mem();
    arm_i = 1;
    wait_ticks(1);
    span(0, 3);
    chk("R2 start event", event_o, 1);
    chk("R2 start pairs", pair_cnt_o, 0);
    span(1, 2);
    ack_i = 1; @(negedge clk_i); ack_i = 0;
    chk("R8 ack while receiving", event_o, 1);
    span(0, 5);
    span(1, 300);
    chk("R4 event", event_o, 2);
    chk("R4 pairs", pair_cnt_o, 2);
    chk("R3 writes", wcount, 8);
    chk("R3 act0 lo", mem[0], 3);  chk("R3 act0 hi", mem[1], 0);
    chk("R3 gap0 lo", mem[2], 2);  chk("R3 gap0 hi", mem[3], 0);
    chk("R3 act1 lo", mem[4], 5);
    chk("R4 final gap lo", mem[6], 0); chk("R4 final gap hi", mem[7], TO);
    wait_ticks(5);
    chk("R8 held", event_o, 2);
    pulse_ack();
    chk("R8 cleared", event_o, 0);
  endtask

  task automatic t_max_pairs();
    clear_mem();
    wait_ticks(1);
    span(0, 2); span(1, 3);
    span(0, 4); span(1, 1);
    span(0, 1); span(1, 2);
    span(0, 6); span(1, 5);
    line_i = 0;
    wait_ticks(3);
    chk("R5 event", event_o, 2);
    chk("R5 pairs", pair_cnt_o, MP);
    chk("R5 writes", wcount, 16);
    chk("R3 gap1 lo", mem[6], 1);
    chk("R3 act2 lo", mem[8], 1);
    chk("R5 last gap", mem[14], 5);
    span(1, 3); span(0, 3); span(1, 3);
    chk("R2 pending blocks start", event_o, 2);
    chk("R5 no extra writes", wcount, 16);
    pulse_ack();
  endtask

  task automatic t_short_press();
    clear_mem();
    wait_ticks(1);
    line_i = 0;
    wait_ticks(260);
    chk("R6 still receiving", event_o, 1);
    wait_ticks(8);
    line_i = 1;
    wait_ticks(30);
    chk("R6 short event", event_o, 3);
    chk("R6 no writes", wcount, 0);
    pulse_ack();
  endtask

  task automatic t_long_press();
    clear_mem();
    wait_ticks(1);
    line_i = 0;
    wait_ticks(284);
    chk("R7 long event", event_o, 4);
    pulse_ack();
    wait_ticks(12);
    chk("R7 no retrigger while low", event_o, 0);
    chk("R7 no writes", wcount, 0);
    span(1, 5);
    chk("R7 idle after release", event_o, 0);
    span(0, 2);
    chk("R7 rearmed", event_o, 1);
    span(1, 300);
    chk("R4 event after rearm", event_o, 2);
    chk("R3 rearm act", mem[0], 2);
    pulse_ack();
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_disarmed();
    t_timeout_packet();
    t_max_pairs();
    t_short_press();
    t_long_press();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule